// File: doc/BRIEF.md
# Read/Write-Only Memory-Move Processor Core

This block is a 16-bit processor core whose whole instruction set is two operations: move one word from memory into a register, or move one word from a register into memory. All computation comes from option bits carried in the same 16-bit instruction word. These bits pick the register that forms the address and the register that gives or takes the data. They can also apply AND or OR against a fixed constant of all zeros or all ones. They can gate the instruction on the carry flag, and they can mark the next memory word as an inline literal.

Code and data share one 16-bit address space behind a single memory port. A read request on that port returns its data in the following cycle. Each instruction passes through fetch, load, execute and, for reads, a write-back phase. The core is used by placing a program in memory and releasing reset. Constants come in through literal words that are read with ic as the address register. A jump is a literal read whose destination is ic.

Top module: `mvc_core`

## Requirements
- R1: Instruction fields are: bit 15 selects the direction (0 = read, 1 = write), bits 14:12 are the address register, and bits 11:9 are the data register. Register codes are 0 = dp, 1 = dr, 2 = ic, 3 = ir, 4 = io and 5 = st. Codes 6 and 7 read as 0x0000, and a transfer into them changes nothing.
- R2: Each instruction is fetched from address ic, and ic then advances by one. A read takes 4 cycles, a write takes 3 cycles, and an instruction whose condition fails takes 3 cycles.
- R3: Bits 8:7 select the ALU operation: 00 = pass, 01 = AND, 10 = OR, 11 = pass. Bit 6 selects the constant operand: 0 = 0x0000, 1 = 0xFFFF. On a write the ALU acts on the source register value. On a read it acts on the memory word.
- R4: Every executed instruction updates the flags from its ALU result. The zero flag is set exactly when the result is 0x0000. AND and OR clear carry, and pass leaves carry unchanged.
- R5: st reads as carry in bit 0, zero in bit 1 and zeros above. A read into st loads carry from bit 0 and zero from bit 1, and this takes precedence over the ALU flag update. st can be written to memory.
- R6: Bits 5:4 hold the condition: 00 and 11 = always, 01 = only when carry is clear, 10 = only when carry is set. A failed condition performs no memory access and changes no register or flag other than ic.
- R7: When bit 3 (literal) is set, ic advances one more word after the instruction's address has been formed. This happens even when the condition fails. A read whose destination is ic overrides this.
- R8: Reset clears ic, all other registers and both flags. The first cycle after reset is a fetch from address 0x0000.
- R9: io_out always shows the io register.
- R10: mem_rd and mem_wr are never both high. Read data is taken from mem_rdata in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Memory word address |
| mem_rd | output | 1 | Read request; data is expected on mem_rdata in the next cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data |
| io_out | output | 16 | Value of the io register |

## Verification
The hardest case to reach from the ports is a conditional instruction that fails while it carries a literal flag. This case is visible only indirectly: the literal must be skipped rather than executed, and no register may change. The stimulus builds that case by loading st from a literal to force carry clear. It then issues a carry-set read into dr with a literal, and finally stores dr and checks that it is still zero. The cycle of the first memory write confirms that the failed instruction took three cycles. A table of short programs then sweeps the AND/OR/pass operations, the constant select, the condition codes and the carry-in values. Each program writes both the ALU result and st to memory, where the flags can be inspected.

// File: rtl/mvc_pkg.sv
package mvc_pkg;
    localparam int XLEN   = 16;
    localparam int RSEL_W = 3;

    localparam logic [RSEL_W-1:0] RS_DP = 3'd0;
    localparam logic [RSEL_W-1:0] RS_DR = 3'd1;
    localparam logic [RSEL_W-1:0] RS_IC = 3'd2;
    localparam logic [RSEL_W-1:0] RS_IR = 3'd3;
    localparam logic [RSEL_W-1:0] RS_IO = 3'd4;
    localparam logic [RSEL_W-1:0] RS_ST = 3'd5;

    typedef enum logic [1:0] {OP_PASS = 2'd0, OP_AND = 2'd1, OP_OR = 2'd2, OP_PASS2 = 2'd3} alu_op_e;
    typedef enum logic [1:0] {CD_ALW = 2'd0, CD_CCLR = 2'd1, CD_CSET = 2'd2, CD_ALW2 = 2'd3} cond_e;
    typedef enum logic [1:0] {PH_FETCH = 2'd0, PH_LOAD = 2'd1, PH_EXEC = 2'd2, PH_WBK = 2'd3} phase_e;

    typedef struct packed {
        logic              is_write;
        logic [RSEL_W-1:0] areg;
        logic [RSEL_W-1:0] dreg;
        alu_op_e           op;
        logic              kone;
        cond_e             cond;
        logic              lit;
        logic [2:0]        spare;
    } insn_t;

    typedef struct packed {
        phase_e          ph;
        logic [XLEN-1:0] dp;
        logic [XLEN-1:0] dr;
        logic [XLEN-1:0] ic;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] io;
        logic            c;
        logic            z;
    } core_state_t;
endpackage

// File: rtl/mvc_decode.sv
module mvc_decode
    import mvc_pkg::*;
(
    input  logic [XLEN-1:0] word_i,
    input  logic            carry_i,
    output insn_t           insn_o,
    output logic            cond_ok_o
);
    always_comb begin
        insn_o = insn_t'(word_i);
        unique case (insn_o.cond)
            CD_CCLR: cond_ok_o = ~carry_i;
            CD_CSET: cond_ok_o = carry_i;
            default: cond_ok_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/mvc_alu.sv
module mvc_alu
    import mvc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op_i,
    input  logic         kone_i,
    input  logic [W-1:0] a_i,
    output logic [W-1:0] res_o,
    output logic         zero_o,
    output logic         logic_op_o
);
    logic [W-1:0] konst;

    always_comb begin
        konst      = kone_i ? {W{1'b1}} : {W{1'b0}};
        logic_op_o = (op_i == OP_AND) || (op_i == OP_OR);
        unique case (op_i)
            OP_AND:  res_o = a_i & konst;
            OP_OR:   res_o = a_i | konst;
            default: res_o = a_i;
        endcase
        zero_o = (res_o == '0);
    end

    always_comb begin
        // R3
        if (op_i == OP_AND && !kone_i) begin
            and_zero_chk: assert (zero_o);
        end
        // R3
        if (op_i == OP_OR && kone_i) begin
            or_ones_chk: assert (&res_o);
        end
    end
endmodule

// File: rtl/mvc_core.sv
module mvc_core
    import mvc_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_IC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] io_out
);
    localparam core_state_t RESET_STATE = '{ph: PH_FETCH, dp: '0, dr: '0, ic: RESET_IC,
                                            ir: '0, io: '0, c: 1'b0, z: 1'b0};

    core_state_t s_q, s_d;
    insn_t       insn;
    logic        cond_ok;
    logic [XLEN-1:0] alu_in, alu_res, addr_val;
    logic        alu_zero, alu_logic;

    function automatic logic [XLEN-1:0] reg_value(input logic [RSEL_W-1:0] sel, input core_state_t s);
        unique case (sel)
            RS_DP:   return s.dp;
            RS_DR:   return s.dr;
            RS_IC:   return s.ic;
            RS_IR:   return s.ir;
            RS_IO:   return s.io;
            RS_ST:   return {{(XLEN-2){1'b0}}, s.z, s.c};
            default: return '0;
        endcase
    endfunction

    mvc_decode u_dec (
        .word_i    (s_q.ir),
        .carry_i   (s_q.c),
        .insn_o    (insn),
        .cond_ok_o (cond_ok)
    );

    assign alu_in   = (s_q.ph == PH_WBK) ? mem_rdata : reg_value(insn.dreg, s_q);
    assign addr_val = reg_value(insn.areg, s_q);

    mvc_alu #(.W(XLEN)) u_alu (
        .op_i       (insn.op),
        .kone_i     (insn.kone),
        .a_i        (alu_in),
        .res_o      (alu_res),
        .zero_o     (alu_zero),
        .logic_op_o (alu_logic)
    );

    always_comb begin
        s_d       = s_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = s_q.ic;
        mem_wdata = '0;
        unique case (s_q.ph)
            PH_FETCH: begin
                mem_rd   = 1'b1;
                s_d.ic   = s_q.ic + 1'b1;
                s_d.ph   = PH_LOAD;
            end
            PH_LOAD: begin
                s_d.ir = mem_rdata;
                s_d.ph = PH_EXEC;
            end
            PH_EXEC: begin
                if (insn.lit) s_d.ic = s_q.ic + 1'b1;
                s_d.ph = PH_FETCH;
                if (cond_ok) begin
                    mem_addr = addr_val;
                    if (insn.is_write) begin
                        mem_wr    = 1'b1;
                        mem_wdata = alu_res;
                        s_d.z     = alu_zero;
                        if (alu_logic) s_d.c = 1'b0;
                    end else begin
                        mem_rd = 1'b1;
                        s_d.ph = PH_WBK;
                    end
                end
            end
            default: begin
                s_d.z = alu_zero;
                if (alu_logic) s_d.c = 1'b0;
                unique case (insn.dreg)
                    RS_DP: s_d.dp = alu_res;
                    RS_DR: s_d.dr = alu_res;
                    RS_IC: s_d.ic = alu_res;
                    RS_IR: s_d.ir = alu_res;
                    RS_IO: s_d.io = alu_res;
                    RS_ST: begin
                        s_d.c = alu_res[0];
                        s_d.z = alu_res[1];
                    end
                    default: ;
                endcase
                s_d.ph = PH_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_STATE;
        else        s_q <= s_d;
    end

    assign io_out = s_q.io;

    // R10
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R2
    fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_FETCH) |=> (s_q.ic == $past(s_q.ic) + 16'd1) && (s_q.ph == PH_LOAD));

    // R4
    logic_clr_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_EXEC && cond_ok && insn.is_write &&
         (insn.op == OP_AND || insn.op == OP_OR)) |=> !s_q.c);

    // R6
    cond_fail_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_EXEC && !cond_ok) |-> !mem_wr && !mem_rd);

    // R6
    cond_fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_EXEC && !cond_ok) |=> (s_q.dr == $past(s_q.dr)) &&
        (s_q.dp == $past(s_q.dp)) && (s_q.c == $past(s_q.c)) && (s_q.z == $past(s_q.z)));

    // R7
    lit_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_EXEC && insn.lit) |=> (s_q.ic == $past(s_q.ic) + 16'd1));
endmodule

// File: tb/mvc_core_bench.sv
module mvc_core_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, io_out;
    logic        mem_rd, mem_wr;
    logic [15:0] mem [256];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mvc_core u_mvc_core (
        .clk, .rst_n, .mem_addr, .mem_rd, .mem_wr, .mem_wdata, .mem_rdata, .io_out
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    localparam int DP = 0, DR = 1, IC = 2, IO = 4, ST = 5, R6C = 6;
    localparam logic [15:0] SENT = 16'h5A5A;

    function automatic logic [15:0] enc(bit w, int a, int d, int op, bit k, int cond, bit lit);
        return {w, a[2:0], d[2:0], op[1:0], k, cond[1:0], lit, 3'b000};
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    endtask

    // vector: value[21:6] op[5:4] k[3] cond[2:1] cin[0]
    localparam int NV = 10;
    localparam logic [21:0] VEC [NV] = '{
        {16'h1234, 2'd1, 1'b1, 2'd0, 1'b1},
        {16'h1234, 2'd1, 1'b0, 2'd0, 1'b1},
        {16'h0000, 2'd2, 1'b1, 2'd0, 1'b1},
        {16'hA5A5, 2'd2, 1'b0, 2'd0, 1'b1},
        {16'h0000, 2'd0, 1'b1, 2'd0, 1'b1},
        {16'h00FF, 2'd0, 1'b0, 2'd1, 1'b1},
        {16'h00FF, 2'd0, 1'b0, 2'd2, 1'b1},
        {16'h8000, 2'd1, 1'b0, 2'd1, 1'b0},
        {16'h8000, 2'd2, 1'b1, 2'd2, 1'b0},
        {16'h0000, 2'd3, 1'b1, 2'd3, 1'b0}
    };

    initial begin
        int first_wr;
        // R8 reset state
        clear_mem();
        @(negedge clk);
        check("R8 mem_rd in reset", {15'd0, mem_rd}, 16'd1);
        check("R8 mem_addr in reset", mem_addr, 16'h0000);
        check("R8 mem_wr in reset", {15'd0, mem_wr}, 16'd0);
        check("R8 io_out in reset", io_out, 16'h0000);

        // table walk: R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            logic [15:0] val, res, exp_mem;
            int op, cond;
            bit k, cin, ok, c, z;
            val = VEC[v][21:6]; op = int'(VEC[v][5:4]); k = VEC[v][3];
            cond = int'(VEC[v][2:1]); cin = VEC[v][0];
            rst_n = 1'b0;
            clear_mem();
            mem[0]  = enc(0, IC, ST, 0, 0, 0, 1); mem[1] = {15'd0, cin};
            mem[2]  = enc(0, IC, DP, 0, 0, 0, 1); mem[3] = 16'h0080;
            mem[4]  = enc(0, IC, IO, 0, 0, 0, 1); mem[5] = 16'h0081;
            mem[6]  = enc(0, IC, DR, 0, 0, 0, 1); mem[7] = val;
            mem[8]  = enc(1, DP, DR, op, k, cond, 0);
            mem[9]  = enc(1, IO, ST, 0, 0, 0, 0);
            mem[10] = enc(0, IC, IC, 0, 0, 0, 1); mem[11] = 16'h000A;
            mem[16'h80] = SENT;
            @(negedge clk); rst_n = 1'b1;
            repeat (40) @(negedge clk);
            case (op)
                1: res = val & (k ? 16'hFFFF : 16'h0000);
                2: res = val | (k ? 16'hFFFF : 16'h0000);
                default: res = val;
            endcase
            ok = (cond == 1) ? !cin : (cond == 2) ? cin : 1'b1;
            if (ok) begin
                exp_mem = res;
                z = (res == 16'h0000);
                c = (op == 1 || op == 2) ? 1'b0 : cin;
            end else begin
                exp_mem = SENT;
                z = (val == 16'h0000);
                c = cin;
            end
            check($sformatf("R3/R6 vec%0d result word", v), mem[16'h80], exp_mem);
            check($sformatf("R4/R5 vec%0d stored st", v), mem[16'h81], {14'd0, z, c});
        end

        // directed: failed condition with literal, R2 R6 R7 R9 R1
        rst_n = 1'b0;
        clear_mem();
        mem[0]  = enc(0, IC, ST, 0, 0, 0, 1); mem[1] = 16'h0000;
        mem[2]  = enc(0, IC, DR, 0, 0, 2, 1); mem[3] = 16'h1234;
        mem[4]  = enc(0, IC, IO, 0, 0, 0, 1); mem[5] = 16'hBEEF;
        mem[6]  = enc(0, IC, DP, 0, 0, 0, 1); mem[7] = 16'h0082;
        mem[8]  = enc(1, DP, DR, 0, 0, 0, 0);
        mem[9]  = enc(0, IC, DP, 0, 0, 0, 1); mem[10] = 16'h0083;
        mem[11] = enc(1, DP, R6C, 2, 0, 0, 0);
        mem[12] = enc(0, IC, IC, 0, 0, 0, 1); mem[13] = 16'h000C;
        mem[16'h82] = SENT; mem[16'h83] = SENT;
        @(negedge clk); rst_n = 1'b1;
        first_wr = -1;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (mem_wr && first_wr < 0) begin
                first_wr = i;
                check("R10 write address", mem_addr, 16'h0082);
            end
        end
        check("R2/R6 first write cycle", first_wr[15:0], 16'd17);
        check("R6/R7 dr unchanged by failed literal read", mem[16'h82], 16'h0000);
        check("R9 io_out after io load", io_out, 16'hBEEF);
        check("R1 code 6 reads zero", mem[16'h83], 16'h0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule